// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer clocked by its own slow clock. Software talks to it over a small single-cycle register bus with a registered read path. Every control action is a magic value written to a 16-bit key register. One value opens the divider and reload registers for writing and another closes them. A third value starts the countdown and a fourth refreshes it. Once started, a down-counter runs from the reload value at a rate set by a power-of-two divider. When it runs out, the block raises a reset request for exactly one clock. It then reloads and keeps counting.

A new divider or reload value does not take effect at once. It is carried across a modelled clock-domain boundary with a fixed latency of `SYNC_LAT` cycles. A pair of busy flags in the status register shows which updates are still in flight. The counter picks up the settled values at its next load: a start, a refresh or an expiry. No register write can stop a running watchdog; only the block's reset can.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the watchdog is idle, the configuration registers are locked, `rst_req_o` is low, and the reads return: divider 0, reload 0xFFF, status 0.
- R2: Key value 0x5555 unlocks the divider and reload registers. Key value 0x0000 locks them. Any key value other than 0x5555, 0x0000, 0xCCCC and 0xAAAA also locks them. Writes to the divider or reload register while locked leave the register unchanged.
- R3: Key value 0xCCCC starts an idle watchdog. `rst_req_o` goes high for exactly one cycle, (reload+1)·(4<<div) clock edges after the edge that took the start write.
- R4: Key value 0xAAAA on a running watchdog restarts the full timeout from that write's edge. On an idle watchdog it has no effect.
- R5: The divider field (offset 0x04) sets the divide ratio to 4<<div. A written value above MAX_DIV_LOG2−2 is stored as MAX_DIV_LOG2−2; the default gives a largest ratio of 256.
- R6: Status (offset 0x0C) bit 0 is the divider-update busy flag and bit 1 is the reload-update busy flag. Each flag is set by an accepted write and clears SYNC_LAT (3) cycles later.
- R7: A settled divider or reload value is used only from the next counter load (start, refresh or expiry). A period already running keeps its old length.
- R8: A running watchdog cannot be stopped. Lock, undefined and repeated start keys do not change the running timeout. After an expiry, counting continues with a new full period.
- R9: Read data is registered and appears one cycle after the address. Key (0x00) reads 0, window (0x10) reads 0xFFF, and unmapped addresses read 0.
- R10: The reload register (offset 0x08) is 12 bits wide. Write-data bits above bit 11 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
A key write acts on the edge that takes it. The reset request is therefore due exactly (reload+1)·(4<<div) edges after that edge. The bench numbers every edge, records the edge of each write and of each reset pulse, and compares the difference with the timeout it computes. Register reads are sampled on the falling edge after the address edge. Busy flags are read on the cycle after the write, when they must be set, and again after several idle cycles, when they must be clear. A new configuration is given those idle cycles to settle before the load that is expected to use it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_LOCK    = 16'h0000;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

  localparam logic [4:0] ADR_KEY  = 5'h00;
  localparam logic [4:0] ADR_DIV  = 5'h04;
  localparam logic [4:0] ADR_RLD  = 5'h08;
  localparam logic [4:0] ADR_STAT = 5'h0C;
  localparam logic [4:0] ADR_WIN  = 5'h10;
endpackage

// File: rtl/wdog_xfer.sv
// Shadow register plus a fixed-latency hand-over to the counter side.
module wdog_xfer #(
  parameter int W = 4,
  parameter int LAT = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] eff,
  output logic         pend
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= INIT;
      eff    <= INIT;
      pend   <= 1'b0;
      cnt    <= '0;
    end else if (wr_en) begin
      shadow <= wr_val;
      pend   <= 1'b1;
      cnt    <= CW'(LAT);
    end else if (pend) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        eff  <= shadow;
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int RLD_W = 12,
  parameter int PR_MAX = 6,
  parameter int PR_W = 3,
  parameter int SYNC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_key,
  output logic              refresh_key,
  output logic              active,
  output logic              unlocked,
  output logic [PR_W-1:0]   pr_shadow,
  output logic [PR_W-1:0]   pr_eff,
  output logic              pr_pend,
  output logic [RLD_W-1:0]  rld_shadow,
  output logic [RLD_W-1:0]  rld_eff,
  output logic              rld_pend
);
  logic            key_wr, pr_wr, rld_wr;
  logic [PR_W-1:0] pr_val;

  assign key_wr      = bus_we && (bus_addr == ADDR_W'(ADR_KEY));
  assign start_key   = key_wr && (bus_wdata == DATA_W'(KEY_START));
  assign refresh_key = key_wr && (bus_wdata == DATA_W'(KEY_REFRESH));
  assign pr_wr       = bus_we && unlocked && (bus_addr == ADDR_W'(ADR_DIV));
  assign rld_wr      = bus_we && unlocked && (bus_addr == ADDR_W'(ADR_RLD));
  assign pr_val      = (bus_wdata > DATA_W'(PR_MAX)) ? PR_W'(PR_MAX) : PR_W'(bus_wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      active   <= 1'b0;
    end else if (key_wr) begin
      if (bus_wdata == DATA_W'(KEY_UNLOCK))
        unlocked <= 1'b1;
      else if (!start_key && !refresh_key)
        unlocked <= 1'b0;
      if (start_key)
        active <= 1'b1;
    end
  end

  wdog_xfer #(.W(PR_W), .LAT(SYNC_LAT), .INIT('0)) u_pr_xfer (
    .clk(clk), .rst(rst), .wr_en(pr_wr), .wr_val(pr_val),
    .shadow(pr_shadow), .eff(pr_eff), .pend(pr_pend)
  );

  wdog_xfer #(.W(RLD_W), .LAT(SYNC_LAT), .INIT({RLD_W{1'b1}})) u_rld_xfer (
    .clk(clk), .rst(rst), .wr_en(rld_wr), .wr_val(RLD_W'(bus_wdata)),
    .shadow(rld_shadow), .eff(rld_eff), .pend(rld_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(ADR_DIV):  bus_rdata <= DATA_W'(pr_shadow);
        ADDR_W'(ADR_RLD):  bus_rdata <= DATA_W'(rld_shadow);
        ADDR_W'(ADR_STAT): bus_rdata <= DATA_W'({rld_pend, pr_pend});
        ADDR_W'(ADR_WIN):  bus_rdata <= DATA_W'({RLD_W{1'b1}});
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_divider.sv
// Power-of-two tick generator; the ratio is latched at each counter load.
module wdog_divider #(
  parameter int PR_W = 3,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            load,
  input  logic [PR_W-1:0] pr_in,
  output logic            tick
);
  logic [PR_W-1:0] pr_cur;
  logic [CW-1:0]   presc;
  logic [CW:0]     ratio;

  assign ratio = (CW+1)'(4) << pr_cur;
  assign tick  = active && (presc == CW'(ratio - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_cur <= '0;
      presc  <= '0;
    end else if (load) begin
      pr_cur <= pr_in;
      presc  <= '0;
    end else if (active) begin
      presc <= tick ? '0 : presc + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int RLD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [RLD_W-1:0] rld_in,
  output logic             expire,
  output logic             rst_req
);
  logic [RLD_W-1:0] cnt;

  assign expire = tick && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (load || expire)
        cnt <= rld_in;
      else if (tick)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int RLD_W = 12,
  parameter int MAX_DIV_LOG2 = 8,
  parameter int SYNC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req_o
);
  localparam int PR_MAX = MAX_DIV_LOG2 - 2;
  localparam int PR_W = $clog2(PR_MAX + 1);

  logic             start_key, refresh_key, active, unlocked;
  logic [PR_W-1:0]  pr_shadow, pr_eff;
  logic             pr_pend, rld_pend;
  logic [RLD_W-1:0] rld_shadow, rld_eff;
  logic             load_req, expire, tick;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RLD_W(RLD_W),
    .PR_MAX(PR_MAX), .PR_W(PR_W), .SYNC_LAT(SYNC_LAT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_key(start_key), .refresh_key(refresh_key),
    .active(active), .unlocked(unlocked),
    .pr_shadow(pr_shadow), .pr_eff(pr_eff), .pr_pend(pr_pend),
    .rld_shadow(rld_shadow), .rld_eff(rld_eff), .rld_pend(rld_pend)
  );

  assign load_req = (start_key && !active) || (refresh_key && active);

  wdog_divider #(.PR_W(PR_W), .CW(MAX_DIV_LOG2)) u_div (
    .clk(clk), .rst(rst), .active(active), .load(load_req || expire),
    .pr_in(pr_eff), .tick(tick)
  );

  wdog_downcnt #(.RLD_W(RLD_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_req), .tick(tick),
    .rld_in(rld_eff), .expire(expire), .rst_req(rst_req_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int PR_W = 3,
  parameter int PR_MAX = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rst_req_o,
  input logic              active,
  input logic              unlocked,
  input logic [PR_W-1:0]   pr_shadow,
  input logic [PR_W-1:0]   pr_eff,
  input logic              pr_pend
);
  // R3
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  // R3
  rst_when_running_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> active);
  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> active);
  // R2
  locked_div_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && bus_we && bus_addr == ADDR_W'(ADR_DIV)) |=> $stable(pr_shadow));
  // R6
  div_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pr_pend) |-> (pr_eff == pr_shadow));
  // R9
  key_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(ADR_KEY)) |=> (bus_rdata == '0));
  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    pr_shadow <= PR_W'(PR_MAX));
endmodule

bind keyed_wdog wdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PR_W(PR_W), .PR_MAX(PR_MAX)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .active(active),
  .unlocked(unlocked), .pr_shadow(pr_shadow), .pr_eff(pr_eff),
  .pr_pend(pr_pend)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int PR_MAX = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req_o;

  int cyc = 0, n_tot = 0, n_fail = 0;
  int rst_cnt = 0, last_rst = 0, wr_edge = 0;

  keyed_wdog u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req_o(rst_req_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && rst_req_o) begin
    rst_cnt  <= rst_cnt + 1;
    last_rst <= cyc;
  end

  function automatic int exp_to(int r, int p);
    int pc = (p > PR_MAX) ? PR_MAX : p;
    return (r + 1) * (4 << pc);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    wr_edge = cyc;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic rdchk(logic [4:0] a, int exp, string req);
    int v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for the next reset pulse after 'base' pulses; returns edges since 'from'
  task automatic wait_rst(int base, int from, output int d);
    int lim = 0;
    while (rst_cnt == base && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    d = (rst_cnt == base) ? -1 : last_rst - from;
  endtask

  task automatic config_wd(int r, int p);
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'(p));
    wr(5'h08, 16'(r));
    wr(5'h00, 16'h0000);
    idle(5);
  endtask

  initial begin
    int d, base, t0, r, p, v;
    void'($urandom(32'd1234));
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(rst_req_o == 1'b0, "R1", rst_req_o, 0);
    rdchk(5'h04, 0, "R1");
    rdchk(5'h08, 12'hFFF, "R1");
    rdchk(5'h0C, 0, "R1");
    // R9 read mapping
    rdchk(5'h00, 0, "R9");
    rdchk(5'h10, 12'hFFF, "R9");
    rdchk(5'h14, 0, "R9");

    // R2 lock behaviour
    wr(5'h04, 16'd3);
    idle(5);
    rdchk(5'h04, 0, "R2");
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'd1);
    rdchk(5'h04, 1, "R2");
    wr(5'h08, 16'd5);
    wr(5'h00, 16'h1234);
    wr(5'h08, 16'd9);
    rdchk(5'h08, 5, "R2");
    wr(5'h00, 16'h5555);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'd9);
    rdchk(5'h08, 5, "R2");

    // R10 reload width, R6 busy flags
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'hF123);
    rdchk(5'h0C, 2, "R6");
    idle(4);
    rdchk(5'h0C, 0, "R6");
    rdchk(5'h08, 12'h123, "R10");
    wr(5'h04, 16'd2);
    rdchk(5'h0C, 1, "R6");
    idle(4);
    rdchk(5'h0C, 0, "R6");
    // R5 clamp
    wr(5'h04, 16'd9);
    rdchk(5'h04, PR_MAX, "R5");
    wr(5'h00, 16'h0000);

    // R4 refresh while idle has no effect
    wr(5'h00, 16'hAAAA);
    idle(200);
    check(rst_cnt == 0, "R4", rst_cnt, 0);

    // R3 start timing (R=3, div 4)
    config_wd(3, 0);
    base = rst_cnt;
    wr(5'h00, 16'hCCCC);
    wait_rst(base, wr_edge, d);
    check(d == exp_to(3, 0), "R3", d, exp_to(3, 0));
    // R8 continues after expiry
    t0 = last_rst;
    base = rst_cnt;
    wait_rst(base, t0, d);
    check(d == exp_to(3, 0), "R8", d, exp_to(3, 0));

    // R4 refresh restarts; R8 stop attempts ignored
    idle(5);
    base = rst_cnt;
    wr(5'h00, 16'hAAAA);
    t0 = wr_edge;
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h1234);
    wr(5'h00, 16'hCCCC);
    wait_rst(base, t0, d);
    check(d == exp_to(3, 0), "R4", d, exp_to(3, 0));
    check(d == exp_to(3, 0), "R8", d, exp_to(3, 0));

    // R7 new reload used only from next load
    idle(2);
    base = rst_cnt;
    wr(5'h00, 16'hAAAA);
    t0 = wr_edge;
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'd7);
    wr(5'h00, 16'h0000);
    wait_rst(base, t0, d);
    check(d == exp_to(3, 0), "R7", d, exp_to(3, 0));
    t0 = last_rst;
    base = rst_cnt;
    wait_rst(base, t0, d);
    check(d == exp_to(7, 0), "R7", d, exp_to(7, 0));

    // R5 clamped ratio in use
    config_wd(2, 7);
    base = rst_cnt;
    wr(5'h00, 16'hAAAA);
    t0 = wr_edge;
    wait_rst(base, t0, d);
    check(d == exp_to(2, 7), "R5", d, exp_to(2, 7));

    // random configurations, R3/R5 timing
    for (int i = 0; i < 10; i++) begin
      r = 2 + int'($urandom % 19);
      p = int'($urandom % 3);
      config_wd(r, p);
      rd(5'h08, v);
      check(v == r, "R10", v, r);
      base = rst_cnt;
      wr(5'h00, 16'hAAAA);
      t0 = wr_edge;
      wait_rst(base, t0, d);
      check(d == exp_to(r, p), "R3", d, exp_to(r, p));
    end

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_tot++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule